// File: doc/BRIEF.md
# Enable and Fault Power Sequencer

This block is the digital control core of a switched-capacitor voltage divider. It watches an enable request, a supply-good comparator, an over-current flag and a digital temperature code. From these it decides when the divider's output switches may close and drives a soft-start ramp that brings the stage up gently. It raises a ready flag once the enable request and the internal supply are both valid. That flag starts the ramp, and output-good follows when the ramp reaches full scale.

Any fault opens the output switches and clears the ramp. The faults are loss of enable or supply, over-current, and an over-temperature trip with hysteresis. Once every fault has gone away the block restarts by itself from a zero ramp. While the enable request is low, the block drives low the enable lines of every monitor except the enable comparator, which keeps standby power at a minimum.

The three comparator-style inputs are asynchronous, so each is synchronised and then debounced before use. The temperature code is taken as a synchronous bus in which one code step equals one degree Celsius, offset by `TEMP_OFS`.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: Each of `en_raw`, `supply_ok_raw` and `ocp_raw` is synchronised and acts only after holding a new level for `DEB_CYC` consecutive sampled cycles. A pulse shorter than that has no effect on any output.
- R2: `por_ready` is high only when the debounced enable and the debounced supply-good are both high. While `por_ready` is low, `out_on` is low and `flt_vec[0]` is 1.
- R3: `mon_en` bit 0 (enable comparator) is always 1. Bits 1 (supply monitor), 2 (thermal sensor) and 3 (current sense) follow the debounced enable, so `mon_en` is 4'b0001 when disabled and 4'b1111 when enabled.
- R4: When no fault is present, `out_on` rises with `ramp` at 0. `ramp` then steps up by one every `STEP_DIV` cycles. `out_good` rises when `ramp` reaches all ones, which takes exactly `STEP_DIV*(2^RAMP_W-1)` cycles after `out_on` rises.
- R5: The thermal fault sets when `temp_code` is at or above the code for 145 °C (code = °C + `TEMP_OFS`, so 209 by default). It forces `out_on` low, `ramp` to 0 and `flt_vec[2]` to 1. A code one step below the trip point has no effect.
- R6: Once set, the thermal fault stays set while the temperature is above 20 °C below the trip point. It clears only at a code of 125 °C or lower.
- R7: While the debounced enable is low, the thermal fault is held clear (`flt_vec[2]`=0) whatever the temperature. On enable, the temperature is evaluated afresh.
- R8: A debounced over-current flag while enabled sets `flt_vec[1]`, forces `out_on` low and clears `ramp`. This applies during the ramp as well as after it. The fault releases by itself when the flag drops.
- R9: While several faults are present, the outputs stay off until the last one clears. The ramp then restarts from 0 with `out_good` low.
- R10: Synchronous active-high reset gives `out_on`=0, `out_good`=0, `ramp`=0, `por_ready`=0, `mon_en`=4'b0001 and `flt_vec`=3'b001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| en_raw | input | 1 | Asynchronous enable request |
| supply_ok_raw | input | 1 | Asynchronous internal-supply-good comparator output |
| ocp_raw | input | 1 | Asynchronous over-current flag |
| temp_code | input | TEMP_W | Temperature code, °C + TEMP_OFS |
| mon_en | output | 4 | Monitor power gates: {current, thermal, supply, enable comparator} |
| por_ready | output | 1 | Enable and supply both valid |
| out_on | output | 1 | Output switches allowed to conduct |
| ramp | output | RAMP_W | Soft-start level |
| out_good | output | 1 | Ramp complete |
| flt_vec | output | 3 | Active faults: {thermal, over-current, undervoltage/disabled} |

## Verification
A wrong internal state shows at the ports within a few cycles. A stuck or mis-set thermal latch appears as `out_on` still low after the temperature has dropped to the clear point, or as a `flt_vec[2]` bit while disabled. A debouncer whose count is off lets a short enable glitch drop `out_good` about ten cycles later. A prescaler or ramp error moves the rise of `out_good` away from the exact 93-cycle distance, or makes `out_on` rise with a non-zero ramp. A missed fault reset leaves `ramp` non-zero after a trip, and this is visible one cycle after the fault flag.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RAMP = 2'd1,
        ST_GOOD = 2'd2
    } seq_state_e;

    localparam int MON_N      = 4;
    localparam int MON_ENCMP  = 0;
    localparam int MON_SUPPLY = 1;
    localparam int MON_THERM  = 2;
    localparam int MON_CURR   = 3;

    localparam int IN_EN  = 0;
    localparam int IN_SUP = 1;
    localparam int IN_OCP = 2;
    localparam int IN_N   = 3;

    typedef struct packed {
        logic therm;
        logic ocp;
        logic uvlo;
    } fault_t;

    function automatic int celsius_to_code(input int celsius, input int ofs);
        return celsius + ofs;
    endfunction

    function automatic logic fault_any(input fault_t f);
        return f.therm | f.ocp | f.uvlo;
    endfunction

endpackage

// File: rtl/pwr_seq_filter.sv
module pwr_seq_filter #(
    parameter int SYNC_N  = 2,
    parameter int DEB_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = $clog2(DEB_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYC - 1);

    logic [SYNC_N-1:0] sync_sh;
    logic              s_lvl;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst) sync_sh <= '0;
        else     sync_sh <= {sync_sh[SYNC_N-2:0], din};
    end

    assign s_lvl = sync_sh[SYNC_N-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= 1'b0;
            cnt  <= '0;
        end else if (s_lvl == dout) begin
            cnt <= '0;
        end else if (cnt == CNT_LAST) begin
            dout <= s_lvl;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R1: the filtered level only moves after a full stable window
    p_deb_window_r1: assert property (@(posedge clk) disable iff (rst)
        (dout != $past(dout)) |-> ($past(cnt) == CNT_LAST));

endmodule

// File: rtl/pwr_seq_thermal.sv
module pwr_seq_thermal #(
    parameter int TEMP_W    = 8,
    parameter int TRIP_CODE = 209,
    parameter int CLR_CODE  = 189
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              tsd
);
    localparam logic [TEMP_W-1:0] TRIP_V = TEMP_W'(TRIP_CODE);
    localparam logic [TEMP_W-1:0] CLR_V  = TEMP_W'(CLR_CODE);

    logic [TEMP_W-1:0] temp_q;
    logic              en_q;

    // sensor sample is gated off while disabled
    always_ff @(posedge clk) begin
        if (rst) begin
            temp_q <= '0;
            en_q   <= 1'b0;
        end else begin
            temp_q <= en ? temp_code : '0;
            en_q   <= en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en || !en_q) begin
            tsd <= 1'b0;
        end else if (!tsd && (temp_q >= TRIP_V)) begin
            tsd <= 1'b1;
        end else if (tsd && (temp_q <= CLR_V)) begin
            tsd <= 1'b0;
        end
    end

    // R7: no thermal fault while disabled
    p_tsd_disabled_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> !tsd);

    // R6: inside the hysteresis band the trip is held
    p_tsd_hyst_r6: assert property (@(posedge clk) disable iff (rst)
        (tsd && en && (temp_q > CLR_V)) |=> tsd);

endmodule

// File: rtl/pwr_seq_softstart.sv
module pwr_seq_softstart
    import pwr_seq_pkg::*;
#(
    parameter int RAMP_W   = 5,
    parameter int STEP_DIV = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fault,
    output logic [RAMP_W-1:0] ramp,
    output logic              out_on,
    output logic              out_good
);
    localparam int PRE_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
    localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(STEP_DIV - 1);
    localparam logic [RAMP_W-1:0] RAMP_MAX  = {RAMP_W{1'b1}};
    localparam logic [RAMP_W-1:0] RAMP_NEAR = RAMP_MAX - 1'b1;

    seq_state_e       state;
    logic [PRE_W-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst || fault) begin
            state <= ST_OFF;
            ramp  <= '0;
            pre   <= '0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    state <= ST_RAMP;
                    ramp  <= '0;
                    pre   <= '0;
                end
                ST_RAMP: begin
                    if (pre == PRE_LAST) begin
                        pre  <= '0;
                        ramp <= ramp + 1'b1;
                        if (ramp == RAMP_NEAR) state <= ST_GOOD;
                    end else begin
                        pre <= pre + 1'b1;
                    end
                end
                ST_GOOD: begin
                    state <= ST_GOOD;
                end
                default: begin
                    state <= ST_OFF;
                    ramp  <= '0;
                    pre   <= '0;
                end
            endcase
        end
    end

    assign out_on   = (state != ST_OFF);
    assign out_good = (state == ST_GOOD);

    // R4: every start begins at the bottom of the ramp
    p_ramp_from_zero_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(out_on) |-> (ramp == '0));

    // R4: good is only reported at full scale
    p_good_full_r4: assert property (@(posedge clk) disable iff (rst)
        out_good |-> (ramp == RAMP_MAX));

    // R4: the ramp never falls while the switches stay on
    p_ramp_mono_r4: assert property (@(posedge clk) disable iff (rst)
        (out_on && $past(out_on)) |-> (ramp >= $past(ramp)));

    // R9: a fault clears both the switches and the ramp
    p_fault_clear_r9: assert property (@(posedge clk) disable iff (rst)
        fault |=> (!out_on && (ramp == '0)));

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int SYNC_N   = 2,
    parameter int DEB_CYC  = 4,
    parameter int RAMP_W   = 5,
    parameter int STEP_DIV = 3,
    parameter int TEMP_W   = 8,
    parameter int TEMP_OFS = 64,
    parameter int TRIP_C   = 145,
    parameter int HYST_C   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_raw,
    input  logic              supply_ok_raw,
    input  logic              ocp_raw,
    input  logic [TEMP_W-1:0] temp_code,
    output logic [3:0]        mon_en,
    output logic              por_ready,
    output logic              out_on,
    output logic [RAMP_W-1:0] ramp,
    output logic              out_good,
    output logic [2:0]        flt_vec
);
    localparam int TRIP_CODE = celsius_to_code(TRIP_C, TEMP_OFS);
    localparam int CLR_CODE  = celsius_to_code(TRIP_C - HYST_C, TEMP_OFS);

    logic [IN_N-1:0] raw_vec;
    logic [IN_N-1:0] flt_in;
    logic            en_d;
    logic            sup_d;
    logic            ocp_d;
    logic            tsd;
    logic            ocp_act;
    fault_t          flt;

    assign raw_vec[IN_EN]  = en_raw;
    assign raw_vec[IN_SUP] = supply_ok_raw;
    assign raw_vec[IN_OCP] = ocp_raw;

    for (genvar g = 0; g < IN_N; g++) begin : g_filt
        pwr_seq_filter #(
            .SYNC_N (SYNC_N),
            .DEB_CYC(DEB_CYC)
        ) i_filt (
            .clk (clk),
            .rst (rst),
            .din (raw_vec[g]),
            .dout(flt_in[g])
        );
    end

    assign en_d  = flt_in[IN_EN];
    assign sup_d = flt_in[IN_SUP];
    assign ocp_d = flt_in[IN_OCP];

    // monitor power gating: enable comparator always on
    for (genvar m = 0; m < MON_N; m++) begin : g_mon
        if (m == MON_ENCMP) begin : g_keep
            assign mon_en[m] = 1'b1;
        end else begin : g_gate
            assign mon_en[m] = en_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) por_ready <= 1'b0;
        else     por_ready <= en_d & sup_d;
    end

    pwr_seq_thermal #(
        .TEMP_W   (TEMP_W),
        .TRIP_CODE(TRIP_CODE),
        .CLR_CODE (CLR_CODE)
    ) i_therm (
        .clk      (clk),
        .rst      (rst),
        .en       (en_d),
        .temp_code(temp_code),
        .tsd      (tsd)
    );

    assign ocp_act   = ocp_d & en_d;
    assign flt.uvlo  = ~por_ready;
    assign flt.ocp   = ocp_act;
    assign flt.therm = tsd;
    assign flt_vec   = flt;

    pwr_seq_softstart #(
        .RAMP_W  (RAMP_W),
        .STEP_DIV(STEP_DIV)
    ) i_ss (
        .clk     (clk),
        .rst     (rst),
        .fault   (fault_any(flt)),
        .ramp    (ramp),
        .out_on  (out_on),
        .out_good(out_good)
    );

    // R2: without ready the switches are open on the next cycle
    p_uvlo_off_r2: assert property (@(posedge clk) disable iff (rst)
        !por_ready |=> !out_on);

    // R8: an active current limit opens the switches
    p_ocp_off_r8: assert property (@(posedge clk) disable iff (rst)
        ocp_act |=> !out_on);

    // R3: a gated supply monitor can never yield ready
    p_gate_no_ready_r3: assert property (@(posedge clk) disable iff (rst)
        !mon_en[MON_SUPPLY] |=> !por_ready);

    // R5: a thermal trip keeps the stage from reporting good
    p_therm_no_good_r5: assert property (@(posedge clk) disable iff (rst)
        tsd |=> !out_good);

endmodule

// File: tb/test_pwr_seq_ctrl.sv
module test_pwr_seq_ctrl;

    localparam int RAMP_W   = 5;
    localparam int STEP_DIV = 3;
    localparam int TEMP_OFS = 64;
    localparam int RAMP_CYC = STEP_DIV * ((1 << RAMP_W) - 1);

    localparam int S_ON   = 0;
    localparam int S_GOOD = 1;
    localparam int S_POR  = 2;
    localparam int S_RAMP = 3;
    localparam int S_MON  = 4;
    localparam int S_FLT  = 5;
    localparam int S_VAL  = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_raw = 1'b0;
    logic       supply_ok_raw = 1'b0;
    logic       ocp_raw = 1'b0;
    logic [7:0] temp_code = 8'(25 + TEMP_OFS);
    logic [3:0] mon_en;
    logic       por_ready;
    logic       out_on;
    logic [RAMP_W-1:0] ramp;
    logic       out_good;
    logic [2:0] flt_vec;

    int n_cmp  = 0;
    int n_miss = 0;
    bit done   = 1'b0;

    typedef struct {
        string req;
        int    sel;
        int    exp;
        int    act;
    } item_t;

    item_t sb[$];

    always #2.5 clk = ~clk;

    pwr_seq_ctrl i_pwr_seq_ctrl (
        .clk          (clk),
        .rst          (rst),
        .en_raw       (en_raw),
        .supply_ok_raw(supply_ok_raw),
        .ocp_raw      (ocp_raw),
        .temp_code    (temp_code),
        .mon_en       (mon_en),
        .por_ready    (por_ready),
        .out_on       (out_on),
        .ramp         (ramp),
        .out_good     (out_good),
        .flt_vec      (flt_vec)
    );

    function automatic int observe(input int sel);
        case (sel)
            S_ON:    return int'(out_on);
            S_GOOD:  return int'(out_good);
            S_POR:   return int'(por_ready);
            S_RAMP:  return int'(ramp);
            S_MON:   return int'(mon_en);
            S_FLT:   return int'(flt_vec);
            default: return -1;
        endcase
    endfunction

    // monitor: pops expected items and compares against the ports
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            int    act;
            it  = sb.pop_front();
            act = (it.sel == S_VAL) ? it.act : observe(it.sel);
            n_cmp++;
            if (act != it.exp) begin
                n_miss++;
                $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
            end
        end
    end

    task automatic expect_port(input string req, input int sel, input int exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp; it.act = 0;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic expect_val(input string req, input int act, input int exp);
        item_t it;
        it.req = req; it.sel = S_VAL; it.exp = exp; it.act = act;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] tc(input int celsius);
        return 8'(celsius + TEMP_OFS);
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
            $finish;
        end
    end

    initial begin : stim
        int cnt;
        cycles(5);
        rst = 1'b0;
        cycles(1);
        // R10 reset state
        expect_port("R10 out_on", S_ON, 0);
        expect_port("R10 ramp", S_RAMP, 0);
        expect_port("R10 por", S_POR, 0);
        expect_port("R10 mon_en", S_MON, 1);
        expect_port("R10 flt", S_FLT, 1);

        // enable without supply
        en_raw = 1'b1;
        cycles(20);
        expect_port("R3 mon_en enabled", S_MON, 15);
        expect_port("R2 por no supply", S_POR, 0);
        expect_port("R2 out_on no supply", S_ON, 0);
        expect_port("R2 flt uvlo", S_FLT, 1);

        // supply arrives: ramp timing
        supply_ok_raw = 1'b1;
        cnt = 0;
        while (!out_on && cnt < 50) begin cycles(1); cnt++; end
        expect_val("R4 ramp start zero", int'(ramp), 0);
        cnt = 1;
        while (!out_good && cnt < 500) begin cycles(1); cnt++; end
        expect_val("R4 ramp duration", cnt, RAMP_CYC);
        expect_port("R4 ramp full", S_RAMP, 31);
        expect_port("R2 por ready", S_POR, 1);

        // R1 short glitches are ignored
        en_raw = 1'b0; cycles(2); en_raw = 1'b1;
        cycles(20);
        expect_port("R1 enable glitch ignored", S_GOOD, 1);
        supply_ok_raw = 1'b0; cycles(3); supply_ok_raw = 1'b1;
        cycles(20);
        expect_port("R1 supply glitch ignored", S_GOOD, 1);
        expect_port("R1 por kept", S_POR, 1);

        // R2 supply loss
        supply_ok_raw = 1'b0;
        cycles(20);
        expect_port("R2 out off on supply loss", S_ON, 0);
        expect_port("R2 por low", S_POR, 0);
        expect_port("R2 flt uvlo", S_FLT, 1);
        expect_port("R3 mon still on", S_MON, 15);
        supply_ok_raw = 1'b1;
        cycles(RAMP_CYC + 30);
        expect_port("R2 restart good", S_GOOD, 1);

        // R5 / R6 thermal
        temp_code = tc(144);
        cycles(10);
        expect_port("R5 below trip no effect", S_GOOD, 1);
        temp_code = tc(145);
        cycles(10);
        expect_port("R5 trip out off", S_ON, 0);
        expect_port("R5 trip ramp zero", S_RAMP, 0);
        expect_port("R5 trip flt", S_FLT, 4);
        temp_code = tc(126);
        cycles(10);
        expect_port("R6 hysteresis hold", S_ON, 0);
        expect_port("R6 flt held", S_FLT, 4);
        temp_code = tc(125);
        cycles(10);
        expect_port("R6 cleared out on", S_ON, 1);
        expect_port("R6 flt clear", S_FLT, 0);

        // R8 over-current during ramp
        cycles(20);
        expect_port("R8 still ramping", S_GOOD, 0);
        ocp_raw = 1'b1;
        cycles(20);
        expect_port("R8 ocp out off", S_ON, 0);
        expect_port("R8 ocp ramp zero", S_RAMP, 0);
        expect_port("R8 ocp flt", S_FLT, 2);
        ocp_raw = 1'b0;
        cycles(20);
        expect_port("R8 auto release", S_ON, 1);
        cycles(RAMP_CYC + 10);
        expect_port("R8 good after release", S_GOOD, 1);

        // R9 several faults
        ocp_raw = 1'b1;
        temp_code = tc(150);
        cycles(20);
        expect_port("R9 both faults", S_FLT, 6);
        expect_port("R9 out off", S_ON, 0);
        ocp_raw = 1'b0;
        cycles(20);
        expect_port("R9 one left off", S_ON, 0);
        expect_port("R9 thermal left", S_FLT, 4);
        temp_code = tc(100);
        cycles(8);
        expect_port("R9 restart on", S_ON, 1);
        expect_port("R9 restart not good", S_GOOD, 0);
        expect_port("R9 flt clear", S_FLT, 0);

        // R7 thermal ignored while disabled
        temp_code = tc(150);
        en_raw = 1'b0;
        cycles(20);
        expect_port("R7 no thermal flag disabled", S_FLT, 1);
        expect_port("R3 mon gated", S_MON, 1);
        expect_port("R7 out off disabled", S_ON, 0);
        en_raw = 1'b1;
        cycles(20);
        expect_port("R7 evaluated on enable", S_FLT, 4);
        expect_port("R7 out off hot", S_ON, 0);
        temp_code = tc(25);
        cycles(RAMP_CYC + 30);
        expect_port("R7 good after cool", S_GOOD, 1);

        cycles(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_miss);
        $finish;
    end

endmodule